// File: doc/BRIEF.md
# SMBus Packet Error Code Checker with Communication-Fault Status

This block sits beside a bus target's byte engine and command decoder. It watches each byte that crosses the bus and keeps a running CRC-8 over it. On a read, the running value is the packet error code that the target returns after its last data byte. On a write, the block decides at the end of the packet whether the write may be committed or has to be rejected. Three causes feed that decision: a PEC byte that does not match, a PEC byte that is missing while the configuration demands one, and the decoder's flags for an unknown command or bad data. Each cause leaves a sticky bit in a cause register. Their OR appears as the communication-fault flag of both the byte-wide and the word-wide status summaries.

The transaction controller has four states. ST_IDLE waits for a start-of-packet strobe. A start-of-packet strobe clears the CRC and enters ST_BODY from any state. ST_BODY accumulates bytes. It moves to ST_PEC_SEEN when a byte marked as the PEC byte arrives, and to ST_VERDICT on end-of-packet. ST_PEC_SEEN moves to ST_VERDICT on end-of-packet. ST_VERDICT lasts one cycle, issues the write outcome and the cause-set pulses, and then returns to ST_IDLE, or to ST_BODY if a new start-of-packet strobe arrives in that cycle. A repeated START is not signalled, so the CRC keeps running across it.

Top module: `smbus_pec_guard`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00. Each byte is processed MSB first. Every accepted byte that is not marked as the PEC byte is folded in. `rd_pec_o` shows the updated value in the cycle after the byte.
- R2: A start-of-packet strobe resets `rd_pec_o` to 0x00 on the next cycle. The bytes that follow, including a second address byte after a repeated START, all go into the same CRC.
- R3: A write whose PEC byte equals the running CRC, and which has no decoder flag, gives a one-cycle `wr_commit_o` pulse in the cycle after end-of-packet. It leaves the cause register unchanged. `wr_commit_o` and `wr_reject_o` are never high together.
- R4: A write whose PEC byte differs from the running CRC gives a one-cycle `wr_reject_o` pulse in the cycle after end-of-packet. It sets cause bit 7 (0x80) whatever the value of `pec_req_i`.
- R5: A write with no PEC byte is rejected and sets bit 7 when `pec_req_i`=1. The same write is committed with no cause bit when `pec_req_i`=0.
- R6: An unsupported-command flag during a packet, read or write, sets cause bit 6 (0x40). A write carrying that flag is rejected.
- R7: An invalid-data flag during a write sets cause bit 5 (0x20) and rejects the write.
- R8: Cause bits become visible two cycles after end-of-packet. They stay set through later clean packets until `clr_faults_i` clears them on the next cycle. `status_byte_cml_o` and `status_word_cml_o` are both 1 exactly when any cause bit is set.
- R9: A write that lacks a required PEC and also carries the unsupported-command flag sets bits 7 and 6 (0xC0) and is rejected.
- R10: A read packet produces neither `wr_commit_o` nor `wr_reject_o`.
- R11: After reset, `rd_pec_o`=0x00, every cause bit and both summary flags are 0, and no write outcome is pulsed.
- R12: In a write, any byte after the PEC byte counts as a PEC error. It sets bit 7 and the write is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_i | input | 1 | Strobe: START that begins a new packet (no byte in this cycle) |
| eop_i | input | 1 | Strobe: STOP ending the packet |
| byte_vld_i | input | 1 | A byte is present on `byte_i` |
| byte_i | input | 8 | Byte seen on the bus (address, command, data or PEC) |
| pec_mark_i | input | 1 | Qualifies `byte_vld_i`: this byte is the PEC byte |
| is_read_i | input | 1 | Direction of the packet, sampled at end-of-packet (1 = read) |
| pec_req_i | input | 1 | Configuration: writes need a valid PEC byte |
| bad_cmd_i | input | 1 | Decoder flag: unsupported command code |
| bad_data_i | input | 1 | Decoder flag: invalid data for the command |
| clr_faults_i | input | 1 | Strobe: clear all cause bits |
| wr_commit_o | output | 1 | One-cycle pulse: write may take effect |
| wr_reject_o | output | 1 | One-cycle pulse: write must be dropped |
| rd_pec_o | output | 8 | Running CRC, the PEC byte to return on a read |
| status_byte_cml_o | output | 1 | Communication-fault flag of the byte-wide status summary |
| status_word_cml_o | output | 1 | Communication-fault flag of the word-wide status summary |
| comm_cause_o | output | 8 | Sticky cause register (bit 7 PEC, bit 6 command, bit 5 data) |

## Verification
The bench builds the block with its default parameters: an 8-bit byte width, polynomial 0x07 and a zero seed. These are the values the SMBus code needs, and they let the bench compare `rd_pec_o` against its own byte-at-a-time CRC over real address, command and data sequences, including a repeated-START read. The values also put the cause bits at positions 7, 6 and 5, so every combination of PEC, command and data faults, and the stickiness of each bit through a later clean packet, can be observed directly on `comm_cause_o`.

// File: rtl/pec_pkg.sv
package pec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_PEC_SEEN,
        ST_VERDICT
    } txn_state_t;

    // index of each fault cause inside the set vector
    localparam int CAUSE_PEC  = 0;
    localparam int CAUSE_CMD  = 1;
    localparam int CAUSE_DATA = 2;
    localparam int N_CAUSES   = 3;

endpackage

// File: rtl/pec_crc_acc.sv
module pec_crc_acc #(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 8'h07,
    parameter logic [W-1:0] SEED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         upd_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] crc_o
);

    logic [W-1:0] crc_q;
    logic [W-1:0] crc_next;

    // MSB-first serial CRC unrolled over one byte
    always_comb begin
        logic [W-1:0] c;
        logic         fb;
        c = crc_q;
        for (int k = W - 1; k >= 0; k--) begin
            fb = c[W-1] ^ din_i[k];
            c  = {c[W-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        crc_next = c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= SEED;
        else if (clr_i) crc_q <= SEED;
        else if (upd_i) crc_q <= crc_next;
    end

    assign crc_o = crc_q;

    // R2
    crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (crc_o == SEED));

endmodule

// File: rtl/pec_txn_fsm.sv
module pec_txn_fsm
    import pec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sop_i,
    input  logic                eop_i,
    input  logic                byte_vld_i,
    input  logic [W-1:0]        byte_i,
    input  logic                pec_mark_i,
    input  logic                is_read_i,
    input  logic                pec_req_i,
    input  logic                bad_cmd_i,
    input  logic                bad_data_i,
    input  logic [W-1:0]        crc_i,
    output logic                crc_clr_o,
    output logic                crc_upd_o,
    output logic                commit_o,
    output logic                reject_o,
    output logic [N_CAUSES-1:0] set_o
);

    txn_state_t state, nxt;

    logic f_pec_seen, f_pec_bad, f_cmd, f_data, f_read;
    logic in_pkt;
    logic pec_err;

    assign in_pkt = (state == ST_BODY) || (state == ST_PEC_SEEN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        if (sop_i) begin
            nxt = ST_BODY;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_BODY: begin
                    if (eop_i)                          nxt = ST_VERDICT;
                    else if (byte_vld_i && pec_mark_i)  nxt = ST_PEC_SEEN;
                end
                ST_PEC_SEEN: if (eop_i) nxt = ST_VERDICT;
                ST_VERDICT:  nxt = ST_IDLE;
            endcase
        end
    end

    // per-packet flags
    always_ff @(posedge clk) begin
        if (!rst_n || sop_i) begin
            f_pec_seen <= 1'b0;
            f_pec_bad  <= 1'b0;
            f_cmd      <= 1'b0;
            f_data     <= 1'b0;
            f_read     <= 1'b0;
        end else if (in_pkt) begin
            if (bad_cmd_i)  f_cmd  <= 1'b1;
            if (bad_data_i) f_data <= 1'b1;
            if (eop_i)      f_read <= is_read_i;
            if (byte_vld_i) begin
                if (state == ST_PEC_SEEN) begin
                    f_pec_bad <= 1'b1;
                end else if (pec_mark_i) begin
                    f_pec_seen <= 1'b1;
                    f_pec_bad  <= (byte_i != crc_i);
                end
            end
        end
    end

    // outputs
    always_comb begin
        crc_clr_o = sop_i;
        crc_upd_o = byte_vld_i && !sop_i && !pec_mark_i && (state == ST_BODY);
        pec_err   = 1'b0;
        commit_o  = 1'b0;
        reject_o  = 1'b0;
        set_o     = '0;
        if (state == ST_VERDICT) begin
            pec_err = !f_read && (f_pec_bad || (pec_req_i && !f_pec_seen));
            set_o[CAUSE_PEC]  = pec_err;
            set_o[CAUSE_CMD]  = f_cmd;
            set_o[CAUSE_DATA] = f_data;
            if (!f_read) begin
                commit_o = !pec_err && !f_cmd && !f_data;
                reject_o =  pec_err ||  f_cmd ||  f_data;
            end
        end
    end

    // R3
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_o, reject_o}));

    // R3
    verdict_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || reject_o) |-> $past(eop_i));

endmodule

// File: rtl/pec_fault_regs.sv
module pec_fault_regs
    import pec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CAUSES-1:0] set_i,
    input  logic                clr_i,
    output logic [W-1:0]        cause_o,
    output logic                any_o
);

    logic [N_CAUSES-1:0] cause_q;

    for (genvar i = 0; i < N_CAUSES; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (!rst_n)        cause_q[i] <= 1'b0;
            else if (set_i[i]) cause_q[i] <= 1'b1;
            else if (clr_i)    cause_q[i] <= 1'b0;
        end

        // R8
        cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q[i] && !clr_i) |=> cause_q[i]);
    end

    // causes occupy the top bits, PEC highest
    always_comb begin
        cause_o = '0;
        for (int i = 0; i < N_CAUSES; i++) cause_o[W-1-i] = cause_q[i];
    end

    assign any_o = |cause_q;

endmodule

// File: rtl/smbus_pec_guard.sv
module smbus_pec_guard
    import pec_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 8'h07,
    parameter logic [W-1:0] SEED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sop_i,
    input  logic         eop_i,
    input  logic         byte_vld_i,
    input  logic [W-1:0] byte_i,
    input  logic         pec_mark_i,
    input  logic         is_read_i,
    input  logic         pec_req_i,
    input  logic         bad_cmd_i,
    input  logic         bad_data_i,
    input  logic         clr_faults_i,
    output logic         wr_commit_o,
    output logic         wr_reject_o,
    output logic [W-1:0] rd_pec_o,
    output logic         status_byte_cml_o,
    output logic         status_word_cml_o,
    output logic [W-1:0] comm_cause_o
);

    logic                crc_clr, crc_upd;
    logic [W-1:0]        crc_val;
    logic [N_CAUSES-1:0] cause_set;
    logic                any_fault;

    pec_crc_acc #(.W(W), .POLY(POLY), .SEED(SEED)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (crc_clr),
        .upd_i (crc_upd),
        .din_i (byte_i),
        .crc_o (crc_val)
    );

    pec_txn_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sop_i      (sop_i),
        .eop_i      (eop_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .pec_mark_i (pec_mark_i),
        .is_read_i  (is_read_i),
        .pec_req_i  (pec_req_i),
        .bad_cmd_i  (bad_cmd_i),
        .bad_data_i (bad_data_i),
        .crc_i      (crc_val),
        .crc_clr_o  (crc_clr),
        .crc_upd_o  (crc_upd),
        .commit_o   (wr_commit_o),
        .reject_o   (wr_reject_o),
        .set_o      (cause_set)
    );

    pec_fault_regs #(.W(W)) u_faults (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (cause_set),
        .clr_i   (clr_faults_i),
        .cause_o (comm_cause_o),
        .any_o   (any_fault)
    );

    assign rd_pec_o          = crc_val;
    assign status_byte_cml_o = any_fault;
    assign status_word_cml_o = any_fault;

    // R4
    reject_flags_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject_o |=> status_byte_cml_o);

    // R3
    commit_keeps_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit_o && !clr_faults_i) |=> (comm_cause_o == $past(comm_cause_o)));

endmodule

// File: tb/smbus_pec_guard_test.sv
module smbus_pec_guard_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sop_i = 0, eop_i = 0, byte_vld_i = 0, pec_mark_i = 0, is_read_i = 0;
    logic pec_req_i = 0, bad_cmd_i = 0, bad_data_i = 0, clr_faults_i = 0;
    logic [7:0] byte_i = '0;
    logic wr_commit_o, wr_reject_o, status_byte_cml_o, status_word_cml_o;
    logic [7:0] rd_pec_o, comm_cause_o;

    int checks = 0;
    int failures = 0;
    logic  exp_q[$];
    string tag_q[$];
    logic [7:0] pkt[$];
    logic [7:0] exp_cause = '0;

    always #2 clk = ~clk;

    smbus_pec_guard uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] crc_of_pkt();
        logic [7:0] c = 8'h00;
        foreach (pkt[i]) c = ref_crc(c, pkt[i]);
        return c;
    endfunction

    // monitor: every outcome pulse is matched against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (wr_commit_o || wr_reject_o)) begin
            if (wr_commit_o && wr_reject_o) begin
                chk("R3 both outcomes high", 1, 0);
            end else if (exp_q.size() == 0) begin
                chk("R10 unexpected write outcome", {wr_commit_o, wr_reject_o}, 0);
            end else begin
                string t;
                logic  e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, wr_commit_o, e);
            end
        end
    end

    task automatic put_byte(input logic [7:0] b, input logic mark, input logic fc, input logic fd);
        byte_vld_i = 1; byte_i = b; pec_mark_i = mark; bad_cmd_i = fc; bad_data_i = fd;
        @(negedge clk);
        byte_vld_i = 0; pec_mark_i = 0; bad_cmd_i = 0; bad_data_i = 0;
    endtask

    task automatic do_sop();
        sop_i = 1;
        @(negedge clk);
        sop_i = 0;
    endtask

    // mode: 0 no PEC, 1 good PEC, 2 wrong PEC, 3 good PEC then extra byte
    task automatic run_write(input string tag, input int mode, input logic fc, input logic fd);
        logic [7:0] c;
        logic pe;
        logic [7:0] nb;
        c = crc_of_pkt();
        do_sop();
        foreach (pkt[i]) put_byte(pkt[i], 0, fc && (i == 1), fd && (i == 2));
        if (mode == 1 || mode == 3) put_byte(c, 1, 0, 0);
        if (mode == 2) put_byte(c ^ 8'h5A, 1, 0, 0);
        if (mode == 3) put_byte(8'h33, 0, 0, 0);
        pe = (mode == 2) || (mode == 3) || (pec_req_i && mode == 0);
        nb = {pe, fc, fd, 5'b0};
        exp_cause = exp_cause | nb;
        exp_q.push_back(!pe && !fc && !fd);
        tag_q.push_back({tag, " outcome"});
        is_read_i = 0;
        eop_i = 1;
        @(negedge clk);
        eop_i = 0;
        @(negedge clk);
        chk({tag, " cause bits"}, comm_cause_o, exp_cause);
        chk({tag, " R8 status byte flag"}, status_byte_cml_o, exp_cause != 0);
        chk({tag, " R8 status word flag"}, status_word_cml_o, exp_cause != 0);
    endtask

    task automatic clear_faults();
        clr_faults_i = 1;
        @(negedge clk);
        clr_faults_i = 0;
        exp_cause = '0;
        chk("R8 cleared", {comm_cause_o, status_byte_cml_o, status_word_cml_o}, 0);
    endtask

    task automatic run_read(input string tag, input logic fc);
        do_sop();
        chk({tag, " R2 crc cleared by start"}, rd_pec_o, 8'h00);
        put_byte(pkt[0], 0, 0, 0);
        put_byte(pkt[1], 0, fc, 0);
        // repeated START: no strobe, second address byte keeps accumulating
        for (int i = 2; i < pkt.size(); i++) put_byte(pkt[i], 0, 0, 0);
        chk({tag, " R1 R2 read PEC"}, rd_pec_o, crc_of_pkt());
        exp_cause = exp_cause | {1'b0, fc, 6'b0};
        is_read_i = 1;
        eop_i = 1;
        @(negedge clk);
        eop_i = 0;
        @(negedge clk);
        is_read_i = 0;
        chk({tag, " R6 cause bits"}, comm_cause_o, exp_cause);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset rd_pec", rd_pec_o, 0);
        chk("R11 reset causes", comm_cause_o, 0);
        chk("R11 reset flags", {status_byte_cml_o, status_word_cml_o}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R11 no outcome after reset", {wr_commit_o, wr_reject_o}, 0);

        pkt = '{8'hB4, 8'h21, 8'h34, 8'h12};
        pec_req_i = 0;
        run_write("R5 optional PEC absent", 0, 0, 0);
        run_write("R3 good PEC", 1, 0, 0);
        run_write("R4 wrong PEC optional", 2, 0, 0);
        pkt = '{8'hB4, 8'h01, 8'h80};
        run_write("R8 sticky through clean write", 1, 0, 0);
        clear_faults();

        pec_req_i = 1;
        run_write("R5 required PEC absent", 0, 0, 0);
        clear_faults();
        run_write("R3 required PEC good", 1, 0, 0);
        pkt = '{8'hB4, 8'h55, 8'hFF, 8'h00};
        run_write("R7 invalid data", 1, 0, 1);
        clear_faults();
        run_write("R9 missing PEC and bad command", 0, 1, 0);
        clear_faults();
        run_write("R12 byte after PEC", 3, 0, 0);
        clear_faults();
        run_write("R6 bad command write", 1, 1, 0);
        clear_faults();

        pkt = '{8'hB4, 8'h8B, 8'hB5, 8'h3C, 8'hA7};
        run_read("R10 read with bad command", 1);
        clear_faults();
        pkt = '{8'hB4, 8'h20, 8'hB5, 8'h9E};
        run_read("R10 clean read", 0);

        repeat (3) @(negedge clk);
        chk("R10 all expected outcomes seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule